// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block is the slave side of a host processor bus into a device's register space. The host presents an 8-bit address, a read/write select and 16-bit write data. It frames each access with two active-low qualifiers, a chip select and a data strobe. The port answers with an active-low ready. The bidirectional data bus is split here into a write-data input, a read-data output and an output enable. The pad drivers sit outside the block.

A static strap chooses between two bus timings. With the strap low, the port runs an asynchronous, fully interlocked handshake. The qualifiers, select and address first pass through a two-flop synchronizer. Ready then falls once the access is done and stays low until the host withdraws chip select or strobe. With the strap high, the port samples the raw inputs on the bus clock and gives a ready pulse one clock wide. One address is a memory data register, which fronts a background buffer-memory transfer. An access to it is held back while a busy input is high, and it completes on the first clock edge that sees busy low.

Top module: `host_reg_port`

## Requirements
- R1: An access starts only when `cs_ni` and `strobe_ni` are both low together. If either one is low on its own, ready stays high and no register changes.
- R2: With `rd_wr_i` = 1 the access is a read and returns the addressed register on `rdata_o`. With `rd_wr_i` = 0 it is a write and stores `wdata_i` into the addressed register.
- R3: With `sync_mode_i` = 0, `ready_no` falls no earlier than the third rising clock edge after both qualifiers go low. It stays low while both remain low, and it returns high within three clock edges after either qualifier goes high.
- R4: With `sync_mode_i` = 1, `ready_no` is low for exactly one clock cycle. That cycle starts at the edge that samples both qualifiers low. Holding the qualifiers low longer causes no second acknowledge.
- R5: An access to the memory data register (address 8'h80) while `mem_busy_i` is high keeps ready high and performs no write. The access completes at the first clock edge that samples `mem_busy_i` low, and ready falls there. This holds in both modes.
- R6: `data_oe_o` is high only during an acknowledged read. It rises together with the falling edge of ready and is low again once the qualifiers are released. It never rises for a write.
- R7: Addresses 8'h00 to 8'h0F are read/write registers. Address 8'hFF is a read-only identifier that reads 16'hC0DE and ignores writes. Every other address except 8'h80 reads 0 and ignores writes.
- R8: After reset, `ready_no` is high, `data_oe_o` is low and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus / internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_mode_i | input | 1 | Mode strap: 1 clocked, 0 asynchronous handshake |
| cs_ni | input | 1 | Chip select, active low |
| strobe_ni | input | 1 | Data strobe, active low |
| rd_wr_i | input | 1 | 1 read, 0 write |
| addr_i | input | 8 | Register address |
| wdata_i | input | 16 | Write data from host |
| mem_busy_i | input | 1 | Buffer-memory transfer pending |
| rdata_o | output | 16 | Read data to host |
| data_oe_o | output | 1 | Read-data output enable |
| ready_no | output | 1 | Acknowledge, active low (released high) |

## Verification
The hardest case to reach is the stalled memory-data access. The host must keep its qualifiers asserted across a window in which busy is high, and then see ready fall on the one edge that follows busy dropping. In clocked mode the bench holds busy high for several cycles with the request standing, and checks ready at every cycle. It lowers busy on a known falling edge and expects ready low exactly one cycle later. In asynchronous mode the same stall runs behind the synchronizer delay, so the bench polls with a bounded wait. It then reads the register back to confirm that the stalled write landed.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2,
    ST_HOLD = 2'd3
  } hrp_state_e;
endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rst_val_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= rst_val_i;
        else         stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= rst_val_i;
        else         stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hrp_regs.sv
module hrp_regs #(
  parameter int                 ADDR_W   = 8,
  parameter int                 DATA_W   = 16,
  parameter int                 NUM_GP   = 16,
  parameter logic [ADDR_W-1:0]  MDR_ADDR = 8'h80,
  parameter logic [ADDR_W-1:0]  ID_ADDR  = 8'hFF,
  parameter logic [DATA_W-1:0]  ID_VALUE = 16'hC0DE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int GP_AW = (NUM_GP > 1) ? $clog2(NUM_GP) : 1;

  logic [DATA_W-1:0] gp_q [NUM_GP];
  logic [DATA_W-1:0] mdr_q;
  logic              gp_hit, mdr_hit, id_hit;
  logic [GP_AW-1:0]  gp_idx;

  assign gp_idx  = addr_i[GP_AW-1:0];
  assign gp_hit  = (int'(addr_i) < NUM_GP);
  assign mdr_hit = (addr_i == MDR_ADDR);
  assign id_hit  = (addr_i == ID_ADDR);

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   gp_q[g] <= '0;
      else if (we_i && gp_hit && int'(gp_idx) == g)  gp_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              mdr_q <= '0;
    else if (we_i && mdr_hit) mdr_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (gp_hit)       rdata_o = gp_q[gp_idx];
    else if (mdr_hit) rdata_o = mdr_q;
    else if (id_hit)  rdata_o = ID_VALUE;
  end

  // MDR never written while buffer transfer is pending
  assert_mdr_no_write_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && mdr_hit) |-> !mem_busy_i);
endmodule

// File: rtl/hrp_ctrl.sv
module hrp_ctrl
  import hrp_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 16,
  parameter logic [ADDR_W-1:0] MDR_ADDR = 8'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_mode_i,
  // raw inputs (clocked mode)
  input  logic              cs_raw_ni,
  input  logic              strobe_raw_ni,
  input  logic              rd_raw_i,
  input  logic [ADDR_W-1:0] addr_raw_i,
  // synchronized inputs (asynchronous mode)
  input  logic              cs_syn_ni,
  input  logic              strobe_syn_ni,
  input  logic              rd_syn_i,
  input  logic [ADDR_W-1:0] addr_syn_i,
  input  logic              mem_busy_i,
  input  logic [DATA_W-1:0] wdata_i,
  // register file side
  output logic [ADDR_W-1:0] rf_addr_o,
  output logic              rf_we_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  input  logic [DATA_W-1:0] rf_rdata_i,
  // host side
  output logic [DATA_W-1:0] rdata_o,
  output logic              data_oe_o,
  output logic              ready_no
);
  hrp_state_e        state_q, state_d;
  logic              req, sel_rd, mdr_sel, access;
  logic [ADDR_W-1:0] sel_addr;
  logic              cmd_rd_q, cmd_mdr_q;
  logic [DATA_W-1:0] rdata_q;

  assign req      = sync_mode_i ? (!cs_raw_ni && !strobe_raw_ni)
                                : (!cs_syn_ni && !strobe_syn_ni);
  assign sel_rd   = sync_mode_i ? rd_raw_i   : rd_syn_i;
  assign sel_addr = sync_mode_i ? addr_raw_i : addr_syn_i;
  assign mdr_sel  = (sel_addr == MDR_ADDR);

  always_comb begin
    access = 1'b0;
    if (req) begin
      unique case (state_q)
        ST_IDLE: access = !(mdr_sel && mem_busy_i);
        ST_WAIT: access = !mem_busy_i;
        default: access = 1'b0;
      endcase
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (access)   state_d = ST_ACK;
        else if (req) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (!req)        state_d = ST_IDLE;
        else if (access) state_d = ST_ACK;
      end
      ST_ACK: begin
        if (!req)             state_d = ST_IDLE;
        else if (sync_mode_i) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (!req) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cmd_rd_q  <= 1'b0;
      cmd_mdr_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      state_q <= state_d;
      if (access) begin
        cmd_rd_q  <= sel_rd;
        cmd_mdr_q <= mdr_sel;
        if (sel_rd) rdata_q <= rf_rdata_i;
      end
    end
  end

  assign rf_addr_o  = sel_addr;
  assign rf_we_o    = access && !sel_rd;
  assign rf_wdata_o = wdata_i;
  assign rdata_o    = rdata_q;
  assign ready_no   = (state_q != ST_ACK);
  assign data_oe_o  = cmd_rd_q && ((state_q == ST_ACK) || (state_q == ST_HOLD));

  assert_ack_needs_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_no) |-> $past(req));

  assert_async_ready_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_mode_i && !ready_no && req) |=> !ready_no);

  assert_sync_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i && !ready_no) |=> ready_no);

  assert_mdr_after_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ready_no) && cmd_mdr_q) |-> !$past(mem_busy_i));

  assert_oe_with_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_oe_o) |-> $fell(ready_no));
endmodule

// File: rtl/host_reg_port.sv
module host_reg_port #(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 16,
  parameter int                NUM_GP   = 16,
  parameter int                SYNC_STG = 2,
  parameter logic [ADDR_W-1:0] MDR_ADDR = 8'h80,
  parameter logic [ADDR_W-1:0] ID_ADDR  = 8'hFF,
  parameter logic [DATA_W-1:0] ID_VALUE = 16'hC0DE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_mode_i,
  input  logic              cs_ni,
  input  logic              strobe_ni,
  input  logic              rd_wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              mem_busy_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              data_oe_o,
  output logic              ready_no
);
  localparam int SW = ADDR_W + 3;

  logic [SW-1:0]     syn_d, syn_q, syn_rst;
  logic [ADDR_W-1:0] rf_addr;
  logic              rf_we;
  logic [DATA_W-1:0] rf_wdata, rf_rdata;

  assign syn_d   = {cs_ni, strobe_ni, rd_wr_i, addr_i};
  assign syn_rst = {2'b11, 1'b1, {ADDR_W{1'b0}}};

  hrp_sync #(.W(SW), .STAGES(SYNC_STG)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_val_i (syn_rst),
    .d_i       (syn_d),
    .q_o       (syn_q)
  );

  hrp_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MDR_ADDR(MDR_ADDR)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sync_mode_i   (sync_mode_i),
    .cs_raw_ni     (cs_ni),
    .strobe_raw_ni (strobe_ni),
    .rd_raw_i      (rd_wr_i),
    .addr_raw_i    (addr_i),
    .cs_syn_ni     (syn_q[SW-1]),
    .strobe_syn_ni (syn_q[SW-2]),
    .rd_syn_i      (syn_q[SW-3]),
    .addr_syn_i    (syn_q[ADDR_W-1:0]),
    .mem_busy_i    (mem_busy_i),
    .wdata_i       (wdata_i),
    .rf_addr_o     (rf_addr),
    .rf_we_o       (rf_we),
    .rf_wdata_o    (rf_wdata),
    .rf_rdata_i    (rf_rdata),
    .rdata_o       (rdata_o),
    .data_oe_o     (data_oe_o),
    .ready_no      (ready_no)
  );

  hrp_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_GP(NUM_GP),
    .MDR_ADDR(MDR_ADDR), .ID_ADDR(ID_ADDR), .ID_VALUE(ID_VALUE)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mem_busy_i (mem_busy_i),
    .addr_i     (rf_addr),
    .we_i       (rf_we),
    .wdata_i    (rf_wdata),
    .rdata_o    (rf_rdata)
  );
endmodule

// File: tb/tb_host_reg_port.sv
`timescale 1ns/1ps
module tb_host_reg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_mode = 1'b1;
  logic        cs_n = 1'b1, stb_n = 1'b1, rw = 1'b1, busy = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        oe, ready_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  host_reg_port dut (
    .clk_i(clk), .rst_ni(rst_n), .sync_mode_i(sync_mode),
    .cs_ni(cs_n), .strobe_ni(stb_n), .rd_wr_i(rw), .addr_i(addr),
    .wdata_i(wdata), .mem_busy_i(busy),
    .rdata_o(rdata), .data_oe_o(oe), .ready_no(ready_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // clocked-mode access: one-cycle strobe
  task automatic s_xfer(input bit rd, input logic [7:0] a, input logic [15:0] d,
                        output logic [15:0] q);
    @(negedge clk);
    rw = rd; addr = a; wdata = d; cs_n = 0; stb_n = 0;
    @(negedge clk);
    chk(ready_n == 0, "R4 ready low at ack", ready_n, 0);
    chk(oe == rd, "R6 oe at ack", oe, rd);
    q = rdata;
    cs_n = 1; stb_n = 1;
    @(negedge clk);
    chk(ready_n == 1, "R4 ready high next cycle", ready_n, 1);
    chk(oe == 0, "R6 oe released", oe, 0);
  endtask

  task automatic a_xfer(input bit rd, input logic [7:0] a, input logic [15:0] d,
                        output logic [15:0] q);
    int n;
    bit seen;
    @(negedge clk);
    rw = rd; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 0; stb_n = 0;
    n = 0; seen = 0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk); n++;
      if (!ready_n) seen = 1;
    end
    chk(seen && n >= 3, "R3 async ready after sync delay", n, 3);
    chk(oe == rd, "R6 async oe", oe, rd);
    q = rdata;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(ready_n == 0, "R3 ready held while strobe low", ready_n, 0);
    end
    stb_n = 1;
    seen = 0;
    for (int i = 0; i < 4 && !seen; i++) begin
      @(negedge clk);
      if (ready_n) seen = 1;
    end
    chk(seen, "R3 ready returns high", ready_n, 1);
    chk(oe == 0, "R6 async oe released", oe, 0);
    cs_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] q;
    chk(ready_n == 1, "R8 reset ready", ready_n, 1);
    chk(oe == 0, "R8 reset oe", oe, 0);
    s_xfer(1, 8'h05, 0, q);
    chk(q == 0, "R8 reg zero after reset", q, 0);
  endtask

  task automatic t_sync_rw();
    logic [15:0] q;
    s_xfer(0, 8'h00, 16'h1357, q);
    s_xfer(0, 8'h0F, 16'hBEEF, q);
    s_xfer(1, 8'h00, 0, q);
    chk(q == 16'h1357, "R2 read reg 0", q, 16'h1357);
    s_xfer(1, 8'h0F, 0, q);
    chk(q == 16'hBEEF, "R2 read reg 15", q, 16'hBEEF);
  endtask

  task automatic t_partial();
    logic [15:0] q;
    s_xfer(0, 8'h03, 16'h00AA, q);
    @(negedge clk);
    rw = 0; addr = 8'h03; wdata = 16'h5555; cs_n = 0; stb_n = 1;
    repeat (3) begin
      @(negedge clk);
      chk(ready_n == 1, "R1 cs alone no ack", ready_n, 1);
    end
    cs_n = 1; stb_n = 0;
    repeat (3) begin
      @(negedge clk);
      chk(ready_n == 1, "R1 strobe alone no ack", ready_n, 1);
    end
    stb_n = 1;
    s_xfer(1, 8'h03, 0, q);
    chk(q == 16'h00AA, "R1 register unchanged", q, 16'h00AA);
  endtask

  task automatic t_sync_hold();
    logic [15:0] q;
    @(negedge clk);
    rw = 0; addr = 8'h02; wdata = 16'h2222; cs_n = 0; stb_n = 0;
    @(negedge clk);
    chk(ready_n == 0, "R4 held strobe ack", ready_n, 0);
    repeat (3) begin
      @(negedge clk);
      chk(ready_n == 1, "R4 no second ack", ready_n, 1);
    end
    cs_n = 1; stb_n = 1;
    @(negedge clk);
    s_xfer(1, 8'h02, 0, q);
    chk(q == 16'h2222, "R4 held write stored", q, 16'h2222);
  endtask

  task automatic t_map();
    logic [15:0] q;
    s_xfer(0, 8'hFF, 16'h1234, q);
    s_xfer(1, 8'hFF, 0, q);
    chk(q == 16'hC0DE, "R7 id read-only", q, 16'hC0DE);
    s_xfer(0, 8'h40, 16'h5555, q);
    s_xfer(1, 8'h40, 0, q);
    chk(q == 0, "R7 unmapped reads zero", q, 0);
    s_xfer(1, 8'h10, 0, q);
    chk(q == 0, "R7 first address past gp", q, 0);
  endtask

  task automatic t_mdr_sync();
    logic [15:0] q;
    s_xfer(0, 8'h80, 16'h0A0A, q);
    @(negedge clk);
    busy = 1; rw = 0; addr = 8'h80; wdata = 16'hB0B0; cs_n = 0; stb_n = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(ready_n == 1, "R5 stalled while busy", ready_n, 1);
    end
    busy = 0;
    @(negedge clk);
    chk(ready_n == 0, "R5 ack edge after busy low", ready_n, 0);
    cs_n = 1; stb_n = 1;
    @(negedge clk);
    s_xfer(1, 8'h80, 0, q);
    chk(q == 16'hB0B0, "R5 stalled write landed", q, 16'hB0B0);
  endtask

  task automatic t_async();
    logic [15:0] q;
    sync_mode = 0;
    a_xfer(0, 8'h07, 16'h7777, q);
    a_xfer(1, 8'h07, 0, q);
    chk(q == 16'h7777, "R2 async readback", q, 16'h7777);
  endtask

  task automatic t_mdr_async();
    logic [15:0] q;
    bit seen;
    @(negedge clk);
    busy = 1; rw = 0; addr = 8'h80; wdata = 16'hC3C3;
    @(negedge clk);
    cs_n = 0; stb_n = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(ready_n == 1, "R5 async stalled", ready_n, 1);
    end
    busy = 0;
    seen = 0;
    for (int i = 0; i < 4 && !seen; i++) begin
      @(negedge clk);
      if (!ready_n) seen = 1;
    end
    chk(seen, "R5 async ack after busy", ready_n, 0);
    cs_n = 1; stb_n = 1;
    repeat (4) @(negedge clk);
    a_xfer(1, 8'h80, 0, q);
    chk(q == 16'hC3C3, "R5 async mdr value", q, 16'hC3C3);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sync_rw();
    t_partial();
    t_sync_hold();
    t_map();
    t_mdr_sync();
    t_async();
    t_mdr_async();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule